// File: doc/BRIEF.md
# Decode Stage Skid-Buffer Flow Controller

This block is the flow-control part of an instruction decode stage for a single thread. Each cycle it receives a group of up to `FETCH_W` instruction tags from fetch and sends at most `DEC_W` of them to the next stage. Each tag holds a sequence number, a squashed bit and a no-source-operands bit. Three downstream stages can ask it to stall. Any instruction it cannot send is kept in an internal skid buffer. When the stall ends, that buffer is emptied before live input is taken again. Fetch is held back with one-cycle block and unblock pulses. A squash request from commit clears everything the stage holds.

Both streams are valid-only. Input slots and output slots are packed from slot 0. There is no ready signal on either side. Fetch must stop issuing new groups in time after a block pulse; the skid buffer is sized to absorb the groups already in flight. Downstream back-pressure reaches this block only through the stall set and clear pulses. All outputs are registered, so every result appears one clock edge after the inputs that caused it.

Top module: `decode_flow`

## Requirements
- R1: While reset is asserted, and after it is released, `stage_state` is Idle (encoding: Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4). All stall flags are clear and all outputs are zero.
- R2: In Running or Idle, valid input tags are forwarded in arrival order, at most `DEC_W` per cycle, packed from output slot 0. A tag with its squashed bit set is dropped and does not use a slot. `out_issue_rdy` equals the tag's no-source bit. Idle becomes Running once a tag is forwarded.
- R3: If live tags are left unsent at the end of a cycle, they move into the skid buffer and the stage enters Blocked. `fetch_block` pulses only if the stage was not already Blocked.
- R4: Bit k of `stall_set` sets stall flag k, and bit k of `stall_clr` clears it; a clear wins over a set in the same cycle. While any flag is set, nothing is forwarded, incoming tags are parked in the skid buffer, and the state is Blocked.
- R5: A clear pulse on a flag that is not set makes `err_unblk` pulse.
- R6: Blocked with all flags clear moves to Unblocking. In Unblocking, up to `DEC_W` tags come from the skid buffer, and new live tags are appended behind the skid contents. `fetch_unblock` pulses and the state returns to Running only when the buffer ends the cycle empty. Blocked with an empty buffer goes straight to Running, pulses `fetch_unblock`, and forwards live input in that same cycle.
- R7: `cmt_squash` has the highest priority. It empties the skid buffer, forwards nothing, sets the state to Squashing, and reports the number of valid incoming tags on `squash_cnt`. It pulses `fetch_unblock` if the state was Blocked or Unblocking.
- R8: `cmt_squashing` (second priority) holds the stage in Squashing, discards the incoming tags, and forwards nothing. From Squashing, the first cycle without a squash or stall goes to Running and forwards live input in that cycle.
- R9: A push beyond the skid capacity pulses `err_ovf`. Excess tags are dropped.
- R10: The skid capacity is `F2D_DELAY*FETCH_W + DEC_W` tags (6 with the default parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | FETCH_W | Valid bits of the fetch group, packed from slot 0 |
| in_seq | input | FETCH_W*SEQ_W | Sequence numbers, slot i in bits [i*SEQ_W +: SEQ_W] |
| in_sq | input | FETCH_W | Squashed bit per slot |
| in_nosrc | input | FETCH_W | No-source-operands bit per slot |
| stall_set | input | 3 | Per-downstream stall set pulses |
| stall_clr | input | 3 | Per-downstream stall clear pulses |
| cmt_squash | input | 1 | Squash request from commit |
| cmt_squashing | input | 1 | Commit is still squashing |
| out_vld | output | DEC_W | Forwarded slot valid bits, packed from slot 0 |
| out_seq | output | DEC_W*SEQ_W | Forwarded sequence numbers |
| out_issue_rdy | output | DEC_W | Ready-to-issue flag per forwarded slot |
| fetch_block | output | 1 | Block pulse to fetch |
| fetch_unblock | output | 1 | Unblock pulse to fetch |
| squash_cnt | output | $clog2(FETCH_W+1) | Incoming tags discarded by a commit squash |
| stage_state | output | 3 | Stage state encoding |
| err_ovf | output | 1 | Skid overflow pulse |
| err_unblk | output | 1 | Clear pulse on a flag that was not set |

## Verification
Forwarding is tried with groups smaller than the width, equal to it and wider than it, and with a squashed tag in the middle. Together these separate slot packing, dropping without using a slot, and the block on leftovers. Stall sequences that keep feeding input while Blocked and while Unblocking show that the skid drains ahead of live input and that appended tags keep their order. They also show that the unblock pulse waits for an empty buffer. A fill past capacity shows the exact number of entries kept. Squashes against a stall and a full buffer show the priority order, the reported count, and that no old tags come out afterwards.

// File: rtl/decode_flow_pkg.sv
package decode_flow_pkg;
  localparam int SEQ_W  = 8;
  localparam int NSTALL = 3;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_BLOCKED = 3'd2,
    ST_UNBLOCK = 3'd3,
    ST_SQUASH  = 3'd4
  } stage_e;

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic             squashed;
    logic             nosrc;
  } itag_t;
endpackage

// File: rtl/decode_stall_track.sv
module decode_stall_track #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_nx_o,
  output logic         err_o
);
  logic [N-1:0] flags_q;

  assign flags_nx_o = (flags_q | set_i) & ~clr_i;
  assign err_o      = |(clr_i & ~(flags_q | set_i));

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_nx_o;
  end
endmodule

// File: rtl/decode_pick.sv
module decode_pick
  import decode_flow_pkg::*;
#(
  parameter int N  = 6,
  parameter int W  = 2,
  localparam int CW = $clog2(N + 1)
) (
  input  logic         src_vld_i [N],
  input  itag_t        src_tag_i [N],
  output logic [W-1:0] out_vld_o,
  output itag_t        out_tag_o [W],
  output logic [CW-1:0] n_cons_o
);
  always_comb begin
    int taken;
    int cons;
    taken     = 0;
    cons      = 0;
    out_vld_o = '0;
    for (int w = 0; w < W; w++) out_tag_o[w] = '0;
    for (int i = 0; i < N; i++) begin
      if (src_vld_i[i] && taken < W) begin
        cons = cons + 1;
        if (!src_tag_i[i].squashed) begin
          out_vld_o[taken] = 1'b1;
          out_tag_o[taken] = src_tag_i[i];
          taken = taken + 1;
        end
      end
    end
    n_cons_o = CW'(cons);
  end
endmodule

// File: rtl/decode_skid.sv
module decode_skid
  import decode_flow_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int PUSH_N = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(PUSH_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic [CW-1:0] pop_n_i,
  input  logic [PW-1:0] push_n_i,
  input  itag_t         push_tag_i [PUSH_N],
  output itag_t         ent_o [DEPTH],
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  itag_t         ent_q [DEPTH];
  itag_t         ent_nx [DEPTH];
  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    int base;
    int src;
    int fill;
    ovf_o = 1'b0;
    base  = int'(cnt_q) - int'(pop_n_i);
    fill  = base;
    for (int j = 0; j < DEPTH; j++) begin
      src = j + int'(pop_n_i);
      ent_nx[j] = (src < DEPTH) ? ent_q[src] : '0;
    end
    for (int p = 0; p < PUSH_N; p++) begin
      if (p < int'(push_n_i)) begin
        if (fill < DEPTH) begin
          ent_nx[fill] = push_tag_i[p];
          fill = fill + 1;
        end else begin
          ovf_o = !clear_i;
        end
      end
    end
    cnt_nx = clear_i ? '0 : CW'(fill);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int j = 0; j < DEPTH; j++) ent_q[j] <= '0;
    end else begin
      cnt_q <= cnt_nx;
      for (int j = 0; j < DEPTH; j++) ent_q[j] <= ent_nx[j];
    end
  end

  assign ent_o = ent_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/decode_flow.sv
module decode_flow
  import decode_flow_pkg::*;
#(
  parameter int FETCH_W   = 4,
  parameter int DEC_W     = 2,
  parameter int F2D_DELAY = 1,
  localparam int SKID_D = F2D_DELAY * FETCH_W + DEC_W,
  localparam int SKW    = $clog2(SKID_D + 1),
  localparam int SQW    = $clog2(FETCH_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FETCH_W-1:0]       in_vld,
  input  logic [FETCH_W*SEQ_W-1:0] in_seq,
  input  logic [FETCH_W-1:0]       in_sq,
  input  logic [FETCH_W-1:0]       in_nosrc,
  input  logic [NSTALL-1:0]        stall_set,
  input  logic [NSTALL-1:0]        stall_clr,
  input  logic                     cmt_squash,
  input  logic                     cmt_squashing,
  output logic [DEC_W-1:0]         out_vld,
  output logic [DEC_W*SEQ_W-1:0]   out_seq,
  output logic [DEC_W-1:0]         out_issue_rdy,
  output logic                     fetch_block,
  output logic                     fetch_unblock,
  output logic [SQW-1:0]           squash_cnt,
  output logic [2:0]               stage_state,
  output logic                     err_ovf,
  output logic                     err_unblk
);
  stage_e state_q, st_mid, st_nx;
  logic [NSTALL-1:0] flags_nx;
  logic stall_err;
  itag_t live [FETCH_W];
  itag_t skid_ent [SKID_D];
  logic [SKW-1:0] skid_cnt;
  logic skid_ovf;
  logic src_vld [SKID_D];
  itag_t src_tag [SKID_D];
  logic [DEC_W-1:0] pk_vld;
  itag_t pk_tag [DEC_W];
  logic [SKW-1:0] n_cons;
  logic dec_en, use_skid;
  logic skid_clear;
  logic [SKW-1:0] pop_n;
  logic [SQW-1:0] push_n;
  itag_t push_tag [FETCH_W];
  logic blk_p, unblk_p;
  logic [SQW-1:0] sq_cnt;
  int live_cnt;

  logic [DEC_W-1:0] out_vld_q;
  itag_t out_tag_q [DEC_W];

  assign live_cnt = $countones(in_vld);

  decode_stall_track #(.N(NSTALL)) u_stall (
    .clk(clk), .rst_n(rst_n), .set_i(stall_set), .clr_i(stall_clr),
    .flags_nx_o(flags_nx), .err_o(stall_err)
  );

  for (genvar g = 0; g < FETCH_W; g++) begin : g_live
    assign live[g] = '{seq: in_seq[g*SEQ_W +: SEQ_W], squashed: in_sq[g], nosrc: in_nosrc[g]};
  end

  // priority resolution of the stage state before decoding
  always_comb begin
    st_mid   = state_q;
    dec_en   = 1'b0;
    use_skid = 1'b0;
    if (cmt_squash || cmt_squashing) begin
      st_mid = ST_SQUASH;
    end else if (|flags_nx) begin
      st_mid = ST_BLOCKED;
    end else begin
      dec_en = 1'b1;
      if (state_q == ST_BLOCKED)     st_mid = (skid_cnt == '0) ? ST_RUN : ST_UNBLOCK;
      else if (state_q == ST_SQUASH) st_mid = ST_RUN;
      use_skid = (st_mid == ST_UNBLOCK);
    end
  end

  for (genvar g = 0; g < SKID_D; g++) begin : g_src
    if (g < FETCH_W) begin : g_both
      assign src_vld[g] = use_skid ? (g < int'(skid_cnt)) : in_vld[g];
      assign src_tag[g] = use_skid ? skid_ent[g] : live[g];
    end else begin : g_skid_only
      assign src_vld[g] = use_skid && (g < int'(skid_cnt));
      assign src_tag[g] = use_skid ? skid_ent[g] : '0;
    end
  end

  decode_pick #(.N(SKID_D), .W(DEC_W)) u_pick (
    .src_vld_i(src_vld), .src_tag_i(src_tag),
    .out_vld_o(pk_vld), .out_tag_o(pk_tag), .n_cons_o(n_cons)
  );

  // actions for the cycle
  always_comb begin
    int left;
    st_nx      = st_mid;
    skid_clear = 1'b0;
    pop_n      = '0;
    push_n     = '0;
    blk_p      = 1'b0;
    unblk_p    = 1'b0;
    sq_cnt     = '0;
    left       = 0;
    for (int j = 0; j < FETCH_W; j++) push_tag[j] = '0;
    if (cmt_squash) begin
      skid_clear = 1'b1;
      sq_cnt     = SQW'(live_cnt);
      unblk_p    = (state_q == ST_BLOCKED) || (state_q == ST_UNBLOCK);
    end else if (cmt_squashing) begin
      st_nx = ST_SQUASH;
    end else if (|flags_nx) begin
      push_n = SQW'(live_cnt);
      for (int j = 0; j < FETCH_W; j++) push_tag[j] = live[j];
      blk_p = (state_q != ST_BLOCKED);
    end else begin
      if (state_q == ST_BLOCKED && skid_cnt == '0) unblk_p = 1'b1;
      if (use_skid) begin
        pop_n  = n_cons;
        push_n = SQW'(live_cnt);
        for (int j = 0; j < FETCH_W; j++) push_tag[j] = live[j];
        if (n_cons == skid_cnt && live_cnt == 0) begin
          unblk_p = 1'b1;
          st_nx   = ST_RUN;
        end
      end else begin
        left = live_cnt - int'(n_cons);
        if (left > 0) begin
          push_n = SQW'(left);
          for (int j = 0; j < FETCH_W; j++)
            if (j + int'(n_cons) < FETCH_W) push_tag[j] = live[j + int'(n_cons)];
          blk_p = (st_mid != ST_BLOCKED);
          st_nx = ST_BLOCKED;
        end else if (st_mid == ST_IDLE && n_cons != '0) begin
          st_nx = ST_RUN;
        end
      end
    end
  end

  decode_skid #(.DEPTH(SKID_D), .PUSH_N(FETCH_W)) u_skid (
    .clk(clk), .rst_n(rst_n), .clear_i(skid_clear), .pop_n_i(pop_n),
    .push_n_i(push_n), .push_tag_i(push_tag), .ent_o(skid_ent),
    .cnt_o(skid_cnt), .ovf_o(skid_ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      out_vld_q     <= '0;
      fetch_block   <= 1'b0;
      fetch_unblock <= 1'b0;
      squash_cnt    <= '0;
      err_ovf       <= 1'b0;
      err_unblk     <= 1'b0;
      for (int w = 0; w < DEC_W; w++) out_tag_q[w] <= '0;
    end else begin
      state_q       <= st_nx;
      out_vld_q     <= dec_en ? pk_vld : '0;
      fetch_block   <= blk_p;
      fetch_unblock <= unblk_p;
      squash_cnt    <= sq_cnt;
      err_ovf       <= skid_ovf;
      err_unblk     <= stall_err;
      for (int w = 0; w < DEC_W; w++) out_tag_q[w] <= dec_en ? pk_tag[w] : '0;
    end
  end

  for (genvar g = 0; g < DEC_W; g++) begin : g_out
    assign out_seq[g*SEQ_W +: SEQ_W] = out_tag_q[g].seq;
    assign out_issue_rdy[g]          = out_vld_q[g] & out_tag_q[g].nosrc;
  end
  assign out_vld     = out_vld_q;
  assign stage_state = state_q;
endmodule

// File: rtl/decode_flow_chk.sv
module decode_flow_chk
  import decode_flow_pkg::*;
#(
  parameter int DW   = 2,
  parameter int CNTW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmt_squash,
  input logic              cmt_squashing,
  input logic [NSTALL-1:0] stall_set,
  input logic [NSTALL-1:0] stall_clr,
  input logic [DW-1:0]     out_vld,
  input logic              fetch_block,
  input logic              fetch_unblock,
  input logic [CNTW-1:0]   squash_cnt,
  input logic [2:0]        stage_state
);
  AST_OUT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_vld & (out_vld + 1'b1)) == '0)); // R2
  AST_OUT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld != '0) |-> (stage_state != 3'(ST_IDLE) && stage_state != 3'(ST_SQUASH))); // R2
  AST_BLOCK_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_block |-> (stage_state == 3'(ST_BLOCKED))); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_set != '0 && stall_clr == '0 && !cmt_squash && !cmt_squashing)
      |=> (stage_state == 3'(ST_BLOCKED))); // R4
  AST_UNBLOCK_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_unblock |-> (stage_state != 3'(ST_UNBLOCK) && stage_state != 3'(ST_IDLE))); // R6
  AST_SQUASH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |=> (stage_state == 3'(ST_SQUASH) && out_vld == '0)); // R7
  AST_SQCNT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_cnt != '0) |-> (stage_state == 3'(ST_SQUASH))); // R7
  AST_SQUASHING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_squashing && !cmt_squash) |=> (stage_state == 3'(ST_SQUASH))); // R8
endmodule

bind decode_flow decode_flow_chk #(.DW(DEC_W), .CNTW(SQW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmt_squash(cmt_squash), .cmt_squashing(cmt_squashing),
  .stall_set(stall_set), .stall_clr(stall_clr), .out_vld(out_vld),
  .fetch_block(fetch_block), .fetch_unblock(fetch_unblock),
  .squash_cnt(squash_cnt), .stage_state(stage_state)
);

// File: tb/decode_flow_bench.sv
`timescale 1ns/1ps
module decode_flow_bench;
  import decode_flow_pkg::*;
  localparam int FW = 4;
  localparam int DW = 2;
  localparam int QW = $clog2(FW + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [FW-1:0] in_vld, in_sq, in_nosrc;
  logic [FW*SEQ_W-1:0] in_seq;
  logic [NSTALL-1:0] stall_set, stall_clr;
  logic cmt_squash, cmt_squashing;
  logic [DW-1:0] out_vld, out_issue_rdy;
  logic [DW*SEQ_W-1:0] out_seq;
  logic fetch_block, fetch_unblock, err_ovf, err_unblk;
  logic [QW-1:0] squash_cnt;
  logic [2:0] stage_state;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  decode_flow u_decode_flow (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_seq(in_seq), .in_sq(in_sq),
    .in_nosrc(in_nosrc), .stall_set(stall_set), .stall_clr(stall_clr),
    .cmt_squash(cmt_squash), .cmt_squashing(cmt_squashing), .out_vld(out_vld),
    .out_seq(out_seq), .out_issue_rdy(out_issue_rdy), .fetch_block(fetch_block),
    .fetch_unblock(fetch_unblock), .squash_cnt(squash_cnt), .stage_state(stage_state),
    .err_ovf(err_ovf), .err_unblk(err_unblk)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic idle_in();
    in_vld = '0; in_seq = '0; in_sq = '0; in_nosrc = '0;
    stall_set = '0; stall_clr = '0; cmt_squash = 1'b0; cmt_squashing = 1'b0;
  endtask

  task automatic feed(input int n, input int base, input logic [FW-1:0] sq, input logic [FW-1:0] ns);
    in_vld = '0; in_seq = '0;
    for (int i = 0; i < n; i++) begin
      in_vld[i] = 1'b1;
      in_seq[i*SEQ_W +: SEQ_W] = SEQ_W'(base + i);
    end
    in_sq = sq & in_vld; in_nosrc = ns & in_vld;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk_out(input int vld, input int s0, input int s1, input string what);
    chk(int'(out_vld), vld, {what, " out_vld"});
    if (vld[0]) chk(int'(out_seq[0 +: SEQ_W]), s0, {what, " slot0 seq"});
    if (vld[1]) chk(int'(out_seq[SEQ_W +: SEQ_W]), s1, {what, " slot1 seq"});
  endtask

  task automatic t_reset();
    chk(int'(stage_state), 0, "R1 state in reset");
    chk(int'(out_vld), 0, "R1 out_vld in reset");
    rst_n = 1'b1; step();
    chk(int'(stage_state), 0, "R1 state after reset");
    chk(int'(fetch_block) + int'(fetch_unblock) + int'(err_ovf) + int'(err_unblk), 0, "R1 pulses after reset");
  endtask

  task automatic t_pass();
    feed(2, 1, 4'b0000, 4'b0010); step();
    chk_out(3, 1, 2, "R2 pass");
    chk(int'(out_issue_rdy), 2, "R2 issue ready");
    chk(int'(stage_state), 1, "R2 idle to running");
    idle_in(); step();
    chk(int'(out_vld), 0, "R2 quiet cycle");
  endtask

  task automatic t_drop();
    feed(3, 5, 4'b0010, 4'b0000); step();
    chk_out(3, 5, 7, "R2 squashed dropped");
    chk(int'(fetch_block), 0, "R2 no block when all consumed");
    idle_in(); step();
  endtask

  task automatic t_width();
    feed(4, 10, 4'b0, 4'b0); step();
    chk_out(3, 10, 11, "R3 width limit");
    chk(int'(fetch_block), 1, "R3 block pulse");
    chk(int'(stage_state), 2, "R3 blocked");
    idle_in(); step();
    chk_out(3, 12, 13, "R6 drain leftovers");
    chk(int'(fetch_unblock), 1, "R6 unblock on empty");
    chk(int'(stage_state), 1, "R6 back to running");
  endtask

  task automatic t_stall();
    stall_set = 3'b010; feed(3, 20, 4'b0, 4'b0); step();
    chk(int'(stage_state), 2, "R4 stall blocks");
    chk(int'(fetch_block), 1, "R4 first block pulse");
    chk(int'(out_vld), 0, "R4 nothing forwarded");
    stall_set = '0; feed(2, 23, 4'b0, 4'b0); step();
    chk(int'(fetch_block), 0, "R3 no repeat block pulse");
    chk(int'(out_vld), 0, "R4 still held");
    idle_in(); stall_clr = 3'b010; step();
    chk(int'(stage_state), 3, "R6 unblocking");
    chk_out(3, 20, 21, "R6 drain first");
    chk(int'(fetch_unblock), 0, "R6 no unblock while full");
    idle_in(); feed(1, 25, 4'b0, 4'b0); step();
    chk_out(3, 22, 23, "R6 skid ahead of live");
    chk(int'(stage_state), 3, "R6 still unblocking");
    idle_in(); step();
    chk_out(3, 24, 25, "R6 appended live in order");
    chk(int'(fetch_unblock), 1, "R6 final unblock");
    chk(int'(stage_state), 1, "R6 running");
  endtask

  task automatic t_err_unblk();
    stall_clr = 3'b100; step();
    chk(int'(err_unblk), 1, "R5 clear of unset flag");
    idle_in(); step();
    chk(int'(err_unblk), 0, "R5 error is a pulse");
  endtask

  task automatic t_ovf();
    stall_set = 3'b001; feed(4, 50, 4'b0, 4'b0); step();
    chk(int'(stage_state), 2, "R9 blocked by stall");
    stall_set = '0; feed(4, 54, 4'b0, 4'b0); step();
    chk(int'(err_ovf), 1, "R9 overflow pulse");
    idle_in(); stall_clr = 3'b001; step();
    chk_out(3, 50, 51, "R10 drain 1");
    idle_in(); step();
    chk_out(3, 52, 53, "R10 drain 2");
    chk(int'(fetch_unblock), 0, "R10 not empty yet");
    step();
    chk_out(3, 54, 55, "R10 capacity six");
    chk(int'(fetch_unblock), 1, "R10 empty after six");
    chk(int'(err_ovf), 0, "R9 overflow cleared");
  endtask

  task automatic t_squash();
    stall_set = 3'b001; feed(3, 60, 4'b0, 4'b0); step();
    stall_set = '0; cmt_squash = 1'b1; feed(3, 63, 4'b0, 4'b0); step();
    chk(int'(stage_state), 4, "R7 squashing");
    chk(int'(squash_cnt), 3, "R7 squash count");
    chk(int'(fetch_unblock), 1, "R7 unblock from blocked");
    chk(int'(out_vld), 0, "R7 no forward");
    idle_in(); cmt_squashing = 1'b1; stall_clr = 3'b001; feed(2, 70, 4'b0, 4'b0); step();
    chk(int'(stage_state), 4, "R8 held squashing");
    chk(int'(out_vld), 0, "R8 no forward");
    chk(int'(squash_cnt), 0, "R8 count only on squash");
    idle_in(); feed(1, 80, 4'b0, 4'b0); step();
    chk_out(1, 80, 0, "R8 resume, old tags gone");
    chk(int'(stage_state), 1, "R8 running");
    idle_in(); step();
    chk(int'(out_vld), 0, "R7 skid emptied");
  endtask

  task automatic t_prio();
    stall_set = 3'b010; cmt_squash = 1'b1; feed(2, 90, 4'b0, 4'b0); step();
    chk(int'(stage_state), 4, "R7 squash beats stall");
    chk(int'(fetch_block), 0, "R7 no block on squash");
    chk(int'(squash_cnt), 2, "R7 count two");
    idle_in(); stall_clr = 3'b010; step();
    chk(int'(stage_state), 1, "R8 squashing to running");
    chk(int'(fetch_unblock), 0, "R7 no unblock from squashing");
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_in();
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_pass();
    t_drop();
    t_width();
    t_stall();
    t_err_unblk();
    t_ovf();
    t_squash();
    t_prio();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule